// File: doc/BRIEF.md
# Source-Routed Crossbar Arbiter

This block is the routing and arbitration core of an eight-link packet switch. Each link carries two virtual channels, so the crossbar has sixteen inputs and eight outputs. Packets move as 16-bit flits under wormhole flow control. A packet opens with a head flit. The low four bits of that flit hold the route tag for this hop. The block strips the tag by shifting the head flit right by four bits, so the next hop finds its own tag in the low bits.

A tag below 8 names one output link directly. A tag from 8 to 15 selects one of eight programmable group masks, and the block uses any member of that group that is not already carrying a packet. When several head flits contend for one output, a high-priority head beats a low-priority head. Among heads of the same priority, the one that has waited longest wins. Once granted, an output stays bound to its input until that input's last flit has passed. Head flits are forwarded in the cycle they are granted, and body flits pass through without change.

Top module: `xbar_route_arb`

## Requirements
- R1: After reset no output is valid, no input is ready, and every group mask is empty, so a head with a group tag (8 to 15) is not granted until its group is written.
- R2: A head flit at an unbound input whose tag t is below 8 is granted onto output t in the same cycle when that output is free. The output has `out_head` set, carries the flit shifted right by 4 with zero fill, and the input sees `in_ready` high.
- R3: A group tag 8+g uses mask g, as written through `tbl_we`/`tbl_sel`/`tbl_mask`. Of the mask bits whose outputs are not bound, the lowest-numbered one is chosen. An empty or fully bound group grants nothing.
- R4: A granted head without `in_last` binds its output to that input. Later flits from that input pass unmodified to that output, up to and including the flit with `in_last`. The output is free in the next cycle.
- R5: A head requesting a bound output is not granted (`in_ready` low) until the binding is released.
- R6: A high-priority (`in_prio`=1) head wins an output over every low-priority head, whatever their ages.
- R7: Each waiting head has a 4-bit age that rises by one in every cycle it is not granted. The age saturates at 15 and returns to 0 on a grant. Within one priority level the larger age wins.
- R8: Heads of equal priority and equal age are resolved in favour of the lower input index.
- R9: A valid non-head flit at an unbound input is ignored: it drives no output and receives no `in_ready`.
- R10: A head that also carries `in_last` (single-flit packet) does not bind its output, so another input can take that output in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Group mask write strobe |
| tbl_sel | input | 3 | Group mask index to write |
| tbl_mask | input | 8 | Output-link bitmask for the group |
| in_valid | input | 16 | Flit present, one bit per input (link*2+channel) |
| in_head | input | 16 | Flit is a packet head carrying a route tag |
| in_last | input | 16 | Flit is the end of its packet |
| in_prio | input | 16 | Priority level of a head (1 = high) |
| in_data | input | 256 | Flit data, input i at bits [16i+15:16i] |
| in_ready | output | 16 | Flit accepted this cycle |
| out_valid | output | 8 | Flit present on output link |
| out_head | output | 8 | Output flit is a (tag-stripped) head |
| out_last | output | 8 | Output flit ends the packet |
| out_data | output | 128 | Output flit data, link o at bits [16o+15:16o] |

## Verification
The bench sweeps every input against every single-link tag and every group mask, and checks the result against shift and lowest-bit arithmetic of its own. That catches a design that drops the tag wrongly or picks the wrong group member. Contention scenes are built around bound outputs. One checks that a fresh high-priority head beats an aged low-priority head. Another sets two heads level and checks that the lower index wins. A further scene holds two heads for 20 and 16 cycles. A design whose age counter wraps instead of saturating would then award the output to the wrong one. Stray body flits, single-flit packets and empty groups are also driven, to catch designs that leak data, hold an output too long, or grant from an unwritten table.

// File: rtl/xbar_route_arb.sv
module xbar_route_arb #(
  parameter int NLINK = 8,
  parameter int NVC   = 2,
  parameter int FLITW = 16,
  parameter int TAGW  = 4,
  parameter int AGEW  = 4,
  localparam int NIN  = NLINK * NVC,
  localparam int NGRP = (1 << TAGW) - NLINK,
  localparam int IW   = $clog2(NIN),
  localparam int OW   = $clog2(NLINK),
  localparam int GW   = $clog2(NGRP)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tbl_we,
  input  logic [GW-1:0]          tbl_sel,
  input  logic [NLINK-1:0]       tbl_mask,
  input  logic [NIN-1:0]         in_valid,
  input  logic [NIN-1:0]         in_head,
  input  logic [NIN-1:0]         in_last,
  input  logic [NIN-1:0]         in_prio,
  input  logic [NIN*FLITW-1:0]   in_data,
  output logic [NIN-1:0]         in_ready,
  output logic [NLINK-1:0]       out_valid,
  output logic [NLINK-1:0]       out_head,
  output logic [NLINK-1:0]       out_last,
  output logic [NLINK*FLITW-1:0] out_data
);

  logic [NLINK-1:0] grp [NGRP];
  logic [NLINK-1:0] bnd_vld;
  logic [IW-1:0]    bnd_src [NLINK];
  logic [NIN-1:0]   in_bnd;
  logic [AGEW-1:0]  age [NIN];

  logic [NIN-1:0]   req;
  logic [OW-1:0]    req_dst [NIN];
  logic [NLINK-1:0] gnt_vld;
  logic [IW-1:0]    gnt_src [NLINK];
  logic [NLINK-1:0] hi_req;
  logic [NIN-1:0]   won;
  logic [NIN-1:0]   waiting;

  assign waiting = in_valid & in_head & ~in_bnd;

  always_comb begin
    for (int i = 0; i < NIN; i++) begin
      logic [TAGW-1:0]  tag;
      logic [NLINK-1:0] cand;
      tag = in_data[i*FLITW +: TAGW];
      if (tag < TAGW'(NLINK)) cand = NLINK'(1) << tag;
      else                    cand = grp[GW'(tag - TAGW'(NLINK))];
      cand = cand & ~bnd_vld;
      req[i] = 1'b0;
      req_dst[i] = '0;
      if (waiting[i])
        for (int o = NLINK - 1; o >= 0; o--)
          if (cand[o]) begin
            req[i] = 1'b1;
            req_dst[i] = OW'(o);
          end
    end
  end

  always_comb begin
    won = '0;
    for (int o = 0; o < NLINK; o++) begin
      logic [AGEW:0] best;
      best = '0;
      gnt_vld[o] = 1'b0;
      gnt_src[o] = '0;
      hi_req[o] = 1'b0;
      for (int i = 0; i < NIN; i++)
        if (req[i] && req_dst[i] == OW'(o)) begin
          hi_req[o] = hi_req[o] | in_prio[i];
          if (!gnt_vld[o] || {in_prio[i], age[i]} > best) begin
            gnt_vld[o] = 1'b1;
            gnt_src[o] = IW'(i);
            best = {in_prio[i], age[i]};
          end
        end
      if (gnt_vld[o]) won[gnt_src[o]] = 1'b1;
    end
  end

  always_comb begin
    out_valid = '0;
    out_head  = '0;
    out_last  = '0;
    out_data  = '0;
    for (int o = 0; o < NLINK; o++) begin
      if (bnd_vld[o]) begin
        out_valid[o] = in_valid[bnd_src[o]];
        out_head[o]  = in_head[bnd_src[o]];
        out_last[o]  = in_last[bnd_src[o]];
        out_data[o*FLITW +: FLITW] = in_data[bnd_src[o]*FLITW +: FLITW];
      end else if (gnt_vld[o]) begin
        out_valid[o] = 1'b1;
        out_head[o]  = 1'b1;
        out_last[o]  = in_last[gnt_src[o]];
        out_data[o*FLITW +: FLITW] = in_data[gnt_src[o]*FLITW +: FLITW] >> TAGW;
      end
    end
  end

  assign in_ready = won | (in_bnd & in_valid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bnd_vld <= '0;
      in_bnd  <= '0;
      for (int g = 0; g < NGRP; g++) grp[g] <= '0;
      for (int o = 0; o < NLINK; o++) bnd_src[o] <= '0;
      for (int i = 0; i < NIN; i++) age[i] <= '0;
    end else begin
      if (tbl_we) grp[tbl_sel] <= tbl_mask;
      for (int o = 0; o < NLINK; o++) begin
        if (bnd_vld[o]) begin
          if (in_valid[bnd_src[o]] && in_last[bnd_src[o]]) bnd_vld[o] <= 1'b0;
        end else if (gnt_vld[o] && !in_last[gnt_src[o]]) begin
          bnd_vld[o] <= 1'b1;
          bnd_src[o] <= gnt_src[o];
        end
      end
      for (int i = 0; i < NIN; i++) begin
        if (in_bnd[i]) begin
          if (in_valid[i] && in_last[i]) in_bnd[i] <= 1'b0;
        end else if (won[i] && !in_last[i]) in_bnd[i] <= 1'b1;
        if (won[i] || !waiting[i]) age[i] <= '0;
        else if (age[i] != '1) age[i] <= age[i] + 1'b1;
      end
    end
  end

  for (genvar o = 0; o < NLINK; o++) begin : g_out_chk
    a_r4_hold_until_last: assert property (@(posedge clk) disable iff (!rst_n)
      bnd_vld[o] && !(in_valid[bnd_src[o]] && in_last[bnd_src[o]])
      |=> bnd_vld[o] && $stable(bnd_src[o]));
    a_r5_no_steal: assert property (@(posedge clk) disable iff (!rst_n)
      bnd_vld[o] |-> !gnt_vld[o]);
    a_r6_high_first: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_vld[o] && !in_prio[gnt_src[o]] |-> !hi_req[o]);
    a_r10_single_free: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_vld[o] && in_last[gnt_src[o]] |=> !bnd_vld[o]);
  end

  for (genvar i = 0; i < NIN; i++) begin : g_in_chk
    a_r9_stray_body: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid[i] && !in_head[i] && !in_bnd[i] |-> !in_ready[i]);
    a_r7_age_sat: assert property (@(posedge clk) disable iff (!rst_n)
      waiting[i] && !in_ready[i] && age[i] == '1 |=> age[i] == '1);
  end

endmodule

// File: tb/test_xbar_route_arb.sv
module test_xbar_route_arb;
  localparam int NIN = 16;
  localparam int NL  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tbl_we = 1'b0;
  logic [2:0] tbl_sel = '0;
  logic [7:0] tbl_mask = '0;
  logic [NIN-1:0] iv = '0, ih = '0, il = '0, ip = '0;
  logic [NIN*16-1:0] idata = '0;
  logic [NIN-1:0] in_ready;
  logic [NL-1:0] out_valid, out_head, out_last;
  logic [NL*16-1:0] out_data;

  int runs = 0;
  int fails = 0;

  always #2 clk = ~clk;

  xbar_route_arb i_xbar_route_arb (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_mask(tbl_mask),
    .in_valid(iv), .in_head(ih), .in_last(il), .in_prio(ip), .in_data(idata),
    .in_ready(in_ready), .out_valid(out_valid), .out_head(out_head),
    .out_last(out_last), .out_data(out_data));

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    iv = '0; ih = '0; il = '0; ip = '0; idata = '0;
  endtask

  task automatic put(input int i, input bit h, input bit l, input bit p, input logic [15:0] d);
    iv[i] = 1'b1; ih[i] = h; il[i] = l; ip[i] = p; idata[i*16 +: 16] = d;
  endtask

  function automatic logic [15:0] pay(input int i, input int t);
    return {12'((i * 37 + t * 11 + 5) % 4096), 4'(t)};
  endfunction

  function automatic logic [15:0] od(input int o);
    return out_data[o*16 +: 16];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    #1;
    chk(out_valid == 0 && in_ready == 0, "R1 idle outputs", {out_valid, in_ready}, 0);
    step();
    put(0, 1, 1, 0, 16'h1238);
    #1;
    chk(out_valid == 0 && in_ready == 0, "R1 empty group table", {out_valid, in_ready}, 0);
    step();

    // R2 sweep: all inputs x all single-link tags
    for (int i = 0; i < NIN; i++)
      for (int t = 0; t < NL; t++) begin
        idle();
        put(i, 1, 1, 0, pay(i, t));
        #1;
        chk(out_valid == NL'(1 << t) && out_head[t] && out_last[t] && od(t) == (pay(i, t) >> 4)
            && in_ready == NIN'(1 << i), "R2 single tag", {out_valid, od(t)}, {NL'(1 << t), pay(i, t) >> 4});
        step();
      end
    idle();

    // R3 group sweep
    for (int g = 0; g < 8; g++) begin
      logic [7:0] m;
      int lo;
      m = 8'((g * 29 + 8'h50) & 8'hF0) | 8'(1 << ((g * 3 + 1) % 8));
      lo = 0;
      for (int b = 7; b >= 0; b--) if (m[b]) lo = b;
      tbl_we = 1'b1; tbl_sel = 3'(g); tbl_mask = m;
      step();
      tbl_we = 1'b0;
      put(g, 1, 1, 0, {12'hA5C, 4'(8 + g)});
      #1;
      chk(out_valid == NL'(1 << lo) && od(lo) == 16'h0A5C && in_ready[g], "R3 group lowest member",
          out_valid, NL'(1 << lo));
      step();
      idle();
    end

    // R3 busy member skipped: group 2 = links 1,5,6
    tbl_we = 1'b1; tbl_sel = 3'd2; tbl_mask = 8'b0110_0010;
    step();
    tbl_we = 1'b0;
    put(5, 1, 0, 0, 16'h7771);
    step();
    idle();
    put(5, 0, 0, 0, 16'hBEEF);
    put(6, 1, 1, 0, 16'h333A);
    #1;
    chk(out_valid[5] && od(5) == 16'h0333 && in_ready[6], "R3 busy member skipped", out_valid, 8'h22);
    chk(out_valid[1] && od(1) == 16'hBEEF, "R4 body unmodified", od(1), 16'hBEEF);
    step();
    idle();
    put(5, 0, 1, 0, 16'hCAFE);
    step();
    idle();

    // R4/R5 wormhole hold
    put(2, 1, 0, 0, 16'h1233);
    #1;
    chk(out_valid[3] && out_head[3] && !out_last[3] && od(3) == 16'h0123, "R4 head grant", od(3), 16'h0123);
    step();
    for (int k = 0; k < 3; k++) begin
      idle();
      put(2, 0, 0, 0, 16'(16'h4000 + k));
      put(7, 1, 1, 0, 16'h9873);
      #1;
      chk(od(3) == 16'(16'h4000 + k) && !out_head[3] && in_ready == NIN'(1 << 2), "R5 bound output holds",
          {od(3), in_ready}, {16'(16'h4000 + k), 16'h0004});
      step();
    end
    idle();
    put(2, 0, 1, 0, 16'h5555);
    put(7, 1, 1, 0, 16'h9873);
    #1;
    chk(od(3) == 16'h5555 && out_last[3] && !in_ready[7], "R4 last passes", od(3), 16'h5555);
    step();
    idle();
    put(7, 1, 1, 0, 16'h9873);
    #1;
    chk(out_valid[3] && od(3) == 16'h0987 && in_ready[7], "R4 released after last", od(3), 16'h0987);
    step();
    idle();

    // R6 priority over age
    put(0, 1, 0, 0, 16'h0011);
    step();
    for (int k = 0; k < 3; k++) begin
      idle();
      put(0, 0, 0, 0, 16'h2222);
      put(9, 1, 1, 0, 16'h0091);
      step();
    end
    idle();
    put(0, 0, 1, 0, 16'h2223);
    put(9, 1, 1, 0, 16'h0091);
    put(12, 1, 1, 1, 16'h0C01);
    step();
    idle();
    put(9, 1, 1, 0, 16'h0091);
    put(12, 1, 1, 1, 16'h0C01);
    #1;
    chk(in_ready[12] && !in_ready[9] && od(1) == 16'h00C0, "R6 high beats aged low", in_ready, 16'h1000);
    step();
    idle();
    put(9, 1, 1, 0, 16'h0091);
    #1;
    chk(in_ready[9] && od(1) == 16'h0009, "R6 low served afterwards", od(1), 16'h0009);
    step();
    idle();

    // R8 tie, then R7 aging
    put(0, 1, 1, 0, 16'h0014);
    put(1, 1, 1, 0, 16'h0024);
    #1;
    chk(in_ready == NIN'(1) && od(4) == 16'h0001, "R8 equal age lowest index", in_ready, 1);
    step();
    #1;
    chk(in_ready == NIN'(2) && od(4) == 16'h0002, "R7 older request wins", in_ready, 2);
    step();
    idle();
    put(10, 1, 1, 1, 16'h00A4);
    put(14, 1, 1, 1, 16'h00E4);
    #1;
    chk(in_ready == NIN'(1 << 10), "R8 high-level tie lowest index", in_ready, NIN'(1 << 10));
    step();
    idle();

    // R7 saturation
    put(15, 1, 0, 0, 16'h0F06);
    step();
    for (int k = 0; k < 20; k++) begin
      idle();
      put(15, 0, k == 19, 0, 16'h6666);
      put(4, 1, 1, 0, 16'h0406);
      if (k >= 4) put(3, 1, 1, 0, 16'h0306);
      step();
    end
    idle();
    put(4, 1, 1, 0, 16'h0406);
    put(3, 1, 1, 0, 16'h0306);
    #1;
    chk(in_ready[3] && !in_ready[4] && od(6) == 16'h0030, "R7 saturated ages tie", in_ready, 8);
    step();
    idle();

    // R9 stray body flit
    put(11, 0, 0, 0, 16'h1112);
    #1;
    chk(out_valid == 0 && in_ready == 0, "R9 stray body ignored", {out_valid, in_ready}, 0);
    step();
    idle();

    // R10 single-flit packet does not bind
    put(8, 1, 1, 0, 16'h0805);
    #1;
    chk(out_valid[5] && out_last[5] && in_ready[8], "R10 single flit forwarded", out_valid, 8'h20);
    step();
    idle();
    put(13, 1, 1, 0, 16'h0D05);
    #1;
    chk(out_valid[5] && in_ready[13] && od(5) == 16'h00D0, "R10 output free next cycle", od(5), 16'h00D0);
    step();
    idle();
    step();

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule